// File: doc/BRIEF.md
# Four-Channel Edge Timetagger

This block watches four asynchronous digital inputs and turns every enabled level change into a 64-bit event word. Each channel has two enable bits: one for rising edges and one for falling edges. An event is stamped with a free-running cycle counter that advances once per clock, which gives 8 ns per count at 125 MHz. Software clears the counter with a one-cycle `ts_clear` pulse. The words leave through a valid/ready handshake, so a downstream stream packer can stall the block.

Each input passes through a two-flop synchronizer and then an edge comparator. All enabled edges seen in one cycle form a single group: one timestamp, a hit mask and a polarity mask. The group is written into a small FIFO. If the FIFO is full, the whole group is dropped and a sticky overflow flag is raised. A two-state emitter machine takes groups out of the FIFO and expands each one into one word per hit channel, lowest channel first.

The emitter has two states. In `EM_IDLE` nothing is offered. The transition *IDLE→SEND* happens when the FIFO holds a group: the group is popped into the working registers. In `EM_SEND` the word for the lowest remaining channel is offered. When it is accepted and channels remain, the machine stays in `EM_SEND` (*advance*). When the last channel is accepted, one of two things happens. If the FIFO is not empty, the next group is popped and the machine stays in `EM_SEND` (*reload*). Otherwise the machine returns to `EM_IDLE` (*SEND→IDLE*).

Top module: `edge_timetagger`

## Requirements
- R1: After reset, `evt_valid` and `overflow` are 0, and constant-low inputs produce no events.
- R2: A 0→1 change on a channel whose rise enable is set yields one word with bit 50 = 1. A 1→0 change on a channel whose fall enable is set yields one word with bit 50 = 0.
- R3: Bits 47:0 of a word hold the cycle counter value in the cycle the edge is detected. That is the counter value in the cycle the input changed, plus 2, which is the synchronizer latency.
- R4: An edge whose type is disabled on its channel produces no word.
- R5: Bits 49:48 hold the channel number, 0 to 3, and bits 63:51 are zero.
- R6: Edges on several channels in the same cycle give one word per channel. All of them carry the same timestamp, and they come out in ascending channel order.
- R7: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` stays 1 and `evt_data` does not change.
- R8: The FIFO holds 4 groups, and the emitter holds one more. A group detected while the FIFO is full is discarded and sets `overflow`, which stays 1 until reset. Groups already accepted come out unchanged.
- R9: A `ts_clear` pulse sampled at a clock edge makes the counter read 0 in the following cycle. The counter then increments by 1 every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 4 | Asynchronous digital inputs, one per channel |
| rise_en | input | 4 | Rising-edge enable per channel |
| fall_en | input | 4 | Falling-edge enable per channel |
| ts_clear | input | 1 | Clears the timestamp counter |
| evt_valid | output | 1 | Event word offered |
| evt_ready | input | 1 | Downstream accepts the word |
| evt_data | output | 64 | Event word: ts[47:0], channel[49:48], rising[50] |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
All fifteen non-empty channel masks are toggled together, up and then down, with every enable set. This separates per-channel edge detection from the ascending-order expansion of one shared timestamp. All 256 combinations of rise and fall enables are then swept on simultaneous toggles, which shows that each of the eight enable bits gates only its own channel and polarity. A stalled burst of eight single-channel edges fills the FIFO past capacity. It distinguishes dropped groups from kept ones, checks that the sticky flag is set, and checks that the offered word holds under backpressure. Expected timestamps come from the bench's own count of cycles since each counter clear.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TT_CH     = 4;
    localparam int TT_CH_W   = $clog2(TT_CH);
    localparam int TT_TS_W   = 48;
    localparam int TT_WORD_W = 64;
    localparam int TT_POL_BIT = TT_TS_W + TT_CH_W;

    typedef struct packed {
        logic [TT_TS_W-1:0] ts;
        logic [TT_CH-1:0]   hit;
        logic [TT_CH-1:0]   pol;
    } tt_group_t;

    typedef enum logic [0:0] {
        EM_IDLE = 1'b0,
        EM_SEND = 1'b1
    } tt_em_state_t;

    function automatic logic [TT_CH_W-1:0] tt_first(input logic [TT_CH-1:0] m);
        logic [TT_CH_W-1:0] r;
        r = '0;
        for (int i = TT_CH - 1; i >= 0; i--) begin
            if (m[i]) r = TT_CH_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tt_edge_detect.sv
module tt_edge_detect
    import tt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TT_CH-1:0] din,
    input  logic [TT_CH-1:0] rise_en,
    input  logic [TT_CH-1:0] fall_en,
    output logic [TT_CH-1:0] hit,
    output logic [TT_CH-1:0] pol
);
    generate
        for (genvar c = 0; c < TT_CH; c++) begin : g_ch
            logic s1_q, s2_q, prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q   <= 1'b0;
                    s2_q   <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    s1_q   <= din[c];
                    s2_q   <= s1_q;
                    prev_q <= s2_q;
                end
            end
            always_comb begin
                pol[c] = s2_q & ~prev_q;
                hit[c] = (s2_q & ~prev_q & rise_en[c]) | (~s2_q & prev_q & fall_en[c]);
            end
        end
    endgenerate
endmodule

// File: rtl/tt_group_fifo.sv
module tt_group_fifo
    import tt_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  tt_group_t wr_data,
    input  logic      rd_en,
    output tt_group_t rd_data,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tt_group_t            mem [DEPTH];
    logic [PTR_W-1:0]     wr_ptr, rd_ptr;
    logic [CNT_W-1:0]     count;
    logic                 push, pop;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign push  = wr_en & ~full;
    assign pop   = rd_en & ~empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/tt_emitter.sv
module tt_emitter
    import tt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 grp_empty,
    input  tt_group_t            grp_data,
    output logic                 grp_pop,
    output logic                 evt_valid,
    input  logic                 evt_ready,
    output logic [TT_WORD_W-1:0] evt_data
);
    tt_em_state_t        state_q, state_d;
    logic [TT_TS_W-1:0]  ts_q;
    logic [TT_CH-1:0]    rem_q, pol_q, rem_left, one_hot;
    logic [TT_CH_W-1:0]  idx;
    logic                fire;

    assign idx      = tt_first(rem_q);
    assign one_hot  = TT_CH'(1) << idx;
    assign rem_left = rem_q & ~one_hot;
    assign fire     = (state_q == EM_SEND) & evt_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        grp_pop = 1'b0;
        unique case (state_q)
            EM_IDLE: begin
                if (!grp_empty) begin
                    grp_pop = 1'b1;
                    state_d = EM_SEND;
                end
            end
            EM_SEND: begin
                if (fire && rem_left == '0) begin
                    if (!grp_empty) grp_pop = 1'b1;
                    else            state_d = EM_IDLE;
                end
            end
            default: state_d = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q  <= '0;
            rem_q <= '0;
            pol_q <= '0;
        end else if (grp_pop) begin
            ts_q  <= grp_data.ts;
            rem_q <= grp_data.hit;
            pol_q <= grp_data.pol;
        end else if (fire) begin
            rem_q <= rem_left;
        end
    end

    always_comb begin
        evt_valid = (state_q == EM_SEND);
        evt_data  = '0;
        evt_data[TT_TS_W-1:0]       = ts_q;
        evt_data[TT_TS_W +: TT_CH_W] = idx;
        evt_data[TT_POL_BIT]         = pol_q[idx];
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_data)));
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rem_left != '0) |=>
        (evt_data[TT_TS_W +: TT_CH_W] > $past(evt_data[TT_TS_W +: TT_CH_W])));
endmodule

// File: rtl/edge_timetagger.sv
module edge_timetagger
    import tt_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TT_CH-1:0]     din,
    input  logic [TT_CH-1:0]     rise_en,
    input  logic [TT_CH-1:0]     fall_en,
    input  logic                 ts_clear,
    output logic                 evt_valid,
    input  logic                 evt_ready,
    output logic [TT_WORD_W-1:0] evt_data,
    output logic                 overflow
);
    logic [TT_TS_W-1:0] ts_q;
    logic [TT_CH-1:0]   hit, pol;
    logic               wr_req, fifo_full, fifo_empty, fifo_pop;
    tt_group_t          wr_grp, rd_grp;
    logic               ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n || ts_clear) ts_q <= '0;
        else                    ts_q <= ts_q + 1'b1;
    end

    tt_edge_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .hit     (hit),
        .pol     (pol)
    );

    assign wr_req     = |hit;
    assign wr_grp.ts  = ts_q;
    assign wr_grp.hit = hit;
    assign wr_grp.pol = pol;

    tt_group_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_req),
        .wr_data (wr_grp),
        .rd_en   (fifo_pop),
        .rd_data (rd_grp),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    tt_emitter u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_empty (fifo_empty),
        .grp_data  (rd_grp),
        .grp_pop   (fifo_pop),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_data  (evt_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_q <= 1'b0;
        else if (wr_req && fifo_full)  ovf_q <= 1'b1;
    end
    assign overflow = ovf_q;

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_fmt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_data[TT_WORD_W-1:TT_POL_BIT+1] == '0));
endmodule

// File: tb/edge_timetagger_bench.sv
`timescale 1ns/1ps
module edge_timetagger_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  din = '0, rise_en = '0, fall_en = '0;
    logic        ts_clear = 1'b0, evt_ready = 1'b1;
    logic        evt_valid, overflow;
    logic [63:0] evt_data;

    int errors = 0, checks = 0, bench_ts = 0;
    logic [63:0] cap [64];
    logic [63:0] exp_w [64];
    int ncap = 0, nexp = 0;

    always #5 clk = ~clk;

    edge_timetagger u_edge_timetagger (
        .clk(clk), .rst_n(rst_n), .din(din), .rise_en(rise_en), .fall_en(fall_en),
        .ts_clear(ts_clear), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_data(evt_data), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (rst_n && evt_valid && evt_ready && ncap < 64) begin
            cap[ncap] = evt_data;
            ncap++;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bench_ts++;
        end
    endtask

    task automatic clear_ts();
        ts_clear = 1'b1;
        @(posedge clk); #1;
        ts_clear = 1'b0;
        bench_ts = 0;
    endtask

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] mk(int ch, bit rising, int ts);
        return {13'b0, rising, 2'(ch), 48'(ts)};
    endfunction

    task automatic add_exp(logic [63:0] w);
        exp_w[nexp] = w;
        nexp++;
    endtask

    // R5 (field layout) is checked by every word comparison below
    task automatic compare(string req);
        chk(ncap == nexp, req, "word count", 64'(ncap), 64'(nexp));
        for (int i = 0; i < nexp && i < ncap; i++)
            chk(cap[i] == exp_w[i], req, $sformatf("word %0d", i), cap[i], exp_w[i]);
        ncap = 0;
        nexp = 0;
    endtask

    task automatic pulse_pair(logic [3:0] m, logic [3:0] r, logic [3:0] f, string req);
        int a, b;
        clear_ts();
        rise_en = r;
        fall_en = f;
        a = bench_ts;
        din = din ^ m;
        tick(2);
        b = bench_ts;
        din = din ^ m;
        tick(14);
        for (int c = 0; c < 4; c++) if (m[c] && r[c]) add_exp(mk(c, 1'b1, a + 2));
        for (int c = 0; c < 4; c++) if (m[c] && f[c]) add_exp(mk(c, 1'b0, b + 2));
        compare(req);
    endtask

    initial begin
        int t [8];
        tick(4);
        rst_n = 1'b1;
        tick(6);
        // R1: idle after reset
        chk(evt_valid == 1'b0, "R1", "evt_valid", 64'(evt_valid), 64'd0);
        chk(overflow == 1'b0, "R1", "overflow", 64'(overflow), 64'd0);
        chk(ncap == 0, "R1", "spurious words", 64'(ncap), 64'd0);

        // R9 and R3: edge in the cycle right after a clear carries ts 2
        rise_en = 4'hF; fall_en = 4'hF;
        clear_ts();
        din[2] = 1'b1;
        tick(10);
        add_exp(mk(2, 1'b1, 2));
        compare("R9");
        clear_ts();
        tick(5);
        din[2] = 1'b0;
        tick(10);
        add_exp(mk(2, 1'b0, 7));
        compare("R3");

        // R2 / R6: every channel mask, all enables set
        for (int m = 1; m < 16; m++) pulse_pair(4'(m), 4'hF, 4'hF, "R2_R6");

        // R4: full sweep of rise/fall enables
        for (int r = 0; r < 16; r++)
            for (int f = 0; f < 16; f++) pulse_pair(4'hF, 4'(r), 4'(f), "R4");

        // R8 / R7: stalled burst of 8 single-channel groups
        clear_ts();
        rise_en = 4'hF; fall_en = 4'hF;
        evt_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            t[i] = bench_ts;
            din[0] = ~din[0];
            tick(2);
        end
        tick(4);
        chk(overflow == 1'b1, "R8", "overflow set", 64'(overflow), 64'd1);
        chk(evt_valid == 1'b1, "R7", "valid under stall", 64'(evt_valid), 64'd1);
        chk(evt_data == mk(0, 1'b1, t[0] + 2), "R7", "held word", evt_data, mk(0, 1'b1, t[0] + 2));
        tick(3);
        chk(evt_data == mk(0, 1'b1, t[0] + 2), "R7", "word stable", evt_data, mk(0, 1'b1, t[0] + 2));
        evt_ready = 1'b1;
        tick(12);
        for (int i = 0; i < 5; i++) add_exp(mk(0, (i % 2) == 0, t[i] + 2));
        compare("R8");
        chk(overflow == 1'b1, "R8", "overflow sticky", 64'(overflow), 64'd1);
        chk(evt_valid == 1'b0, "R8", "drained", 64'(evt_valid), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule